// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with APB Registers

This block gathers up to 64 level-sensitive interrupt requests and presents them to a primary interrupt controller as a single active-high line. The requests are grouped into two 32-bit banks. Request `k` lives in bank `k / 32` at bit `k % 32`. Each bank has three registers:

- an enable register, where a 1 admits the request;
- a mask register, where a 1 suppresses the request;
- a read-only status register that shows which requests are currently pending.

Software reaches all of these registers through an APB slave port that never inserts wait states.

The number of wired requests, `NUM_SRC`, is fixed at build time and may be anything from 2 to 64. Flops exist only for request positions below `NUM_SRC`. Every other position reads as zero, even after software writes all ones. A driver can therefore write all ones to both enable registers, find the highest bit that stuck, and learn how many requests the instance has.

Top module: `irqagg_top`

## Requirements
- R1: After reset, every enable bit and every mask bit is 0, both status registers read 0, and `irq_out` is 0.
- R2: The enable registers sit at byte offset 0x00 (requests 0..31) and 0x04 (requests 32..63). A write stores `pwdata` only in bits whose request index is below `NUM_SRC`. All other bits read 0.
- R3: The mask registers sit at byte offset 0x08 (low bank) and 0x0C (high bank). They follow the same implemented-bit rule as R2.
- R4: The status registers sit at byte offset 0x30 (low bank) and 0x34 (high bank). Each status bit reads as request AND enable AND NOT mask. Request 32+k appears at bit k of the high-bank status.
- R5: `irq_out` is the OR of all status bits across both banks, delayed by exactly one `pclk` edge. It is level-sensitive: it falls one edge after the last pending request clears.
- R6: Writes to the status offsets change no register.
- R7: Reads from any other offset, including misaligned ones, return 0. Writes to those offsets change no register.
- R8: `pready` is always 1 and `pslverr` is always 0.
- R9: Mask and enable act independently. A request that is enabled but masked, or unmasked but disabled, shows no status and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte address within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_src | input | NUM_SRC | Level-sensitive interrupt requests |
| irq_out | output | 1 | Registered interrupt line to the primary controller |

## Verification
The assertions take for granted two things about the inputs:

- APB transfers are well formed: `penable` is raised only in the cycle after a setup phase with `psel` held, and the address and data stay stable across both phases.
- The `irq_src` inputs are already synchronous to `pclk`.

The bench keeps within these limits. It drives every transfer as a clean two-cycle setup/access pair and changes requests only one time unit after a rising edge. It runs with `NUM_SRC` set to 40, so the high bank is only partly implemented and the all-ones probe returns a value other than zero or all ones.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int TOTAL_W   = BANK_W * NUM_BANKS;

  // Byte offsets; bank index adds one word
  localparam logic [11:0] OFFS_ENABLE = 12'h000;
  localparam logic [11:0] OFFS_MASK   = 12'h008;
  localparam logic [11:0] OFFS_STATUS = 12'h030;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_ENABLE,
    KIND_MASK,
    KIND_STATUS
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      bank;
  } reg_sel_t;

  // Bits of bank 'bank' that hold a real request
  function automatic logic [BANK_W-1:0] bank_impl(input int num_src, input int bank);
    logic [BANK_W-1:0] r;
    for (int i = 0; i < BANK_W; i++) begin
      r[i] = ((bank * BANK_W + i) < num_src);
    end
    return r;
  endfunction

  // A request is pending when raised, admitted and not suppressed
  function automatic logic [TOTAL_W-1:0] pending_bits(input logic [TOTAL_W-1:0] req,
                                                       input logic [TOTAL_W-1:0] en,
                                                       input logic [TOTAL_W-1:0] msk);
    return req & en & ~msk;
  endfunction

  // Full address compare, misaligned or unknown offsets map to KIND_NONE
  function automatic reg_sel_t decode_addr(input logic [11:0] a);
    reg_sel_t s;
    s.kind = KIND_NONE;
    s.bank = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (a == OFFS_ENABLE + 12'(4 * b)) begin s.kind = KIND_ENABLE; s.bank = b[0]; end
      if (a == OFFS_MASK   + 12'(4 * b)) begin s.kind = KIND_MASK;   s.bank = b[0]; end
      if (a == OFFS_STATUS + 12'(4 * b)) begin s.kind = KIND_STATUS; s.bank = b[0]; end
    end
    return s;
  endfunction

endpackage

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int BANK_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_sel,
  input  logic              wr_msk_sel,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] en_q,
  output logic [BANK_W-1:0] msk_q
);

  localparam logic [BANK_W-1:0] IMPL = bank_impl(NUM_SRC, BANK_IDX);

  logic no_write;
  assign no_write = !wr_en_sel && !wr_msk_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      msk_q <= '0;
    end else begin
      if (wr_en_sel)  en_q  <= wdata & IMPL;
      if (wr_msk_sel) msk_q <= wdata & IMPL;
    end
  end

  // R2
  en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_sel |=> (en_q == ($past(wdata) & IMPL)));

  // R3
  msk_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_msk_sel |=> (msk_q == ($past(wdata) & IMPL)));

  // R6 R7
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_write |=> ($stable(en_q) && $stable(msk_q)));

endmodule

// File: rtl/irqagg_gate.sv
module irqagg_gate
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic [TOTAL_W-1:0] en_all,
  input  logic [TOTAL_W-1:0] msk_all,
  output logic [TOTAL_W-1:0] stat_all,
  output logic               any_pending,
  output logic               irq_q
);

  logic [TOTAL_W-1:0] src_pad;
  assign src_pad     = TOTAL_W'(src);
  assign stat_all    = pending_bits(src_pad, en_all, msk_all);
  assign any_pending = |stat_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pending;
  end

  // R5
  irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == $past(any_pending)));

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               irq_out
);

  logic               wr_strobe;
  reg_sel_t           sel;
  logic [TOTAL_W-1:0] en_all, msk_all, stat_all;
  logic               any_pending;

  assign wr_strobe = psel && penable && pwrite;
  assign sel       = decode_addr(12'(paddr));
  assign pready    = 1'b1;
  assign pslverr   = 1'b0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_en_b, wr_msk_b;
    assign wr_en_b  = wr_strobe && (sel.kind == KIND_ENABLE) && (sel.bank == b[0]);
    assign wr_msk_b = wr_strobe && (sel.kind == KIND_MASK)   && (sel.bank == b[0]);
    irqagg_bank #(.NUM_SRC(NUM_SRC), .BANK_IDX(b)) u_bank (
      .clk        (pclk),
      .rst_n      (presetn),
      .wr_en_sel  (wr_en_b),
      .wr_msk_sel (wr_msk_b),
      .wdata      (pwdata),
      .en_q       (en_all[b*BANK_W +: BANK_W]),
      .msk_q      (msk_all[b*BANK_W +: BANK_W])
    );
  end

  irqagg_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .clk         (pclk),
    .rst_n       (presetn),
    .src         (irq_src),
    .en_all      (en_all),
    .msk_all     (msk_all),
    .stat_all    (stat_all),
    .any_pending (any_pending),
    .irq_q       (irq_out)
  );

  logic [BANK_W-1:0] en_sel_bank, msk_sel_bank, stat_sel_bank;
  assign en_sel_bank   = sel.bank ? en_all[TOTAL_W-1:BANK_W]   : en_all[BANK_W-1:0];
  assign msk_sel_bank  = sel.bank ? msk_all[TOTAL_W-1:BANK_W]  : msk_all[BANK_W-1:0];
  assign stat_sel_bank = sel.bank ? stat_all[TOTAL_W-1:BANK_W] : stat_all[BANK_W-1:0];

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      unique case (sel.kind)
        KIND_ENABLE: prdata = en_sel_bank;
        KIND_MASK:   prdata = msk_sel_bank;
        KIND_STATUS: prdata = stat_sel_bank;
        default:     prdata = '0;
      endcase
    end
  end

  // R9
  irq_needs_enable_chk: assert property (@(posedge pclk) disable iff (!presetn)
    irq_out |-> $past(|(en_all & ~msk_all)));

  // R4
  stat_within_enable_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && sel.kind == KIND_STATUS) |-> ((prdata & (~en_sel_bank | msk_sel_bank)) == '0));

  // R7
  unmapped_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && sel.kind == KIND_NONE) |-> (prdata == '0));

endmodule

// File: tb/irqagg_top_tb_top.sv
`timescale 1ns/1ps
module irqagg_top_tb_top;

  localparam int NSRC = 40;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [NSRC-1:0] irq_src = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] data;
    string       tag;
  } exp_item_t;
  exp_item_t exp_q[$];

  always #2 pclk = ~pclk;

  irqagg_top #(.NUM_SRC(NSRC), .ADDR_W(12)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq_src(irq_src), .irq_out(irq_out)
  );

  // Monitor: compare read data in the access phase, away from the edge
  always @(negedge pclk) begin
    if (presetn && psel && penable) begin
      checks++;
      if (pready !== 1'b1 || pslverr !== 1'b0) begin
        errors++;
        $display("FAIL R8 pready=%b pslverr=%b expected 1/0", pready, pslverr);
      end
      if (!pwrite) begin
        exp_item_t it;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard empty on read, actual %h expected none", prdata);
        end else begin
          it = exp_q.pop_front();
          checks++;
          if (prdata !== it.data) begin
            errors++;
            $display("FAIL %s addr=%h actual %h expected %h", it.tag, paddr, prdata, it.data);
          end
        end
      end
    end
  end

  task automatic apb_xfer(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(posedge pclk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge pclk); #1;
    penable = 1'b1;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    apb_xfer(1'b1, a, d);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_item_t it;
    it.data = exp;
    it.tag  = tag;
    exp_q.push_back(it);
    apb_xfer(1'b0, a, '0);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq_out !== exp) begin
      errors++;
      $display("FAIL %s irq_out actual %b expected %b", tag, irq_out, exp);
    end
  endtask

  task automatic settle();
    @(posedge pclk); @(posedge pclk); #1;
  endtask

  localparam logic [31:0] HI_IMPL = 32'h0000_00FF; // 40 sources, 8 in high bank

  initial begin : wdog
    repeat (100000) @(posedge pclk);
    errors++;
    $display("FAIL watchdog expired, actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge pclk);
    #1 presetn = 1'b1;

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(12'h000, 32'h0, "R1 en lo");
    rd(12'h004, 32'h0, "R1 en hi");
    rd(12'h008, 32'h0, "R1 msk lo");
    rd(12'h00C, 32'h0, "R1 msk hi");
    irq_src = '1;
    rd(12'h030, 32'h0, "R1 stat lo");
    rd(12'h034, 32'h0, "R1 stat hi");
    settle();
    chk_irq(1'b0, "R1 no irq with sources up");

    // R9: masks set first, then enables: enabled but masked gives nothing
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h008, 32'hFFFF_FFFF, "R3 msk lo probe");
    rd(12'h00C, HI_IMPL, "R3 msk hi probe");
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h000, 32'hFFFF_FFFF, "R2 en lo probe");
    rd(12'h004, HI_IMPL, "R2 en hi probe");
    rd(12'h030, 32'h0, "R9 masked stat lo");
    settle();
    chk_irq(1'b0, "R9 masked no irq");

    // R4 R5: unmask low bank partially
    irq_src = '0;
    wr(12'h008, 32'hFFFF_00FF);
    irq_src = 40'h00_0000_0F0F;
    rd(12'h030, 32'h0000_0F00, "R4 stat lo pattern");
    chk_irq(1'b1, "R5 asserted");
    // one-edge latency: drop the source, still high before the edge
    @(posedge pclk); #1;
    irq_src = '0;
    chk_irq(1'b1, "R5 before edge");
    @(posedge pclk); #1;
    chk_irq(1'b0, "R5 level falls one edge later");
    irq_src = 40'h00_0000_0100;
    chk_irq(1'b0, "R5 not yet risen");
    @(posedge pclk); #1;
    chk_irq(1'b1, "R5 rises one edge later");
    irq_src = '0;

    // R4 high-bank mapping: source 33 -> bit 1 of high status
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h00C, 32'h0000_0000);
    irq_src = 40'h02_0000_0000;
    rd(12'h034, 32'h0000_0002, "R4 src33 stat hi");
    rd(12'h030, 32'h0, "R4 src33 stat lo clear");
    settle();
    chk_irq(1'b1, "R4 src33 irq");

    // R6: write to status offsets has no effect
    wr(12'h034, 32'h0000_0000);
    wr(12'h030, 32'hFFFF_FFFF);
    rd(12'h034, 32'h0000_0002, "R6 stat hi kept");
    rd(12'h004, HI_IMPL, "R6 en hi kept");
    rd(12'h00C, 32'h0, "R6 msk hi kept");
    rd(12'h008, 32'hFFFF_FFFF, "R6 msk lo kept");

    // R7: unmapped and misaligned accesses
    wr(12'h010, 32'h0);
    wr(12'h001, 32'h0);
    wr(12'h40C, 32'h0);
    rd(12'h010, 32'h0, "R7 unmapped read");
    rd(12'h002, 32'h0, "R7 misaligned read");
    rd(12'h004, HI_IMPL, "R7 en hi kept");
    rd(12'h000, 32'hFFFF_FFFF, "R7 en lo kept");
    rd(12'h00C, 32'h0, "R7 msk hi kept");

    // R9: unmasked but disabled gives nothing
    wr(12'h004, 32'h0);
    rd(12'h034, 32'h0, "R9 disabled stat hi");
    settle();
    chk_irq(1'b0, "R9 disabled no irq");

    // R2: partial enable write only keeps implemented bits
    wr(12'h004, 32'hA5A5_A5A5);
    rd(12'h004, 32'h0000_00A5, "R2 partial en hi");
    irq_src = '0;
    settle();
    chk_irq(1'b0, "R5 cleared");

    wait (exp_q.size() == 0);
    @(posedge pclk); #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule